// File: doc/BRIEF.md
# Interval Timer Channel with Byte-Wide Count Readout

This block is one channel of an interval timer. It holds a 16-bit down-counter that loses one count on every cycle in which the tick enable is high. A program strobe loads a new starting count. When the count is zero and a tick arrives, the counter wraps to all ones and raises a terminal-count pulse for one cycle.

The count is read through an 8-bit port, so software reads it in two halves: first the low byte, then the high byte. A latch strobe freezes a copy of the count so that both halves come from the same instant. The copy is released on its own once its high byte has been read. Without a latch, reads alternate between the two halves of the running count. In that mode the count may move between the two reads.

Top module: `tick_timer_chan`

## Requirements
- R1: After reset the count is 0, the terminal-count output is low, `rd_data` is 0, no snapshot is held, and the next read returns the low byte.
- R2: In a cycle with `tick_en` high and `prog_stb` low, a nonzero count decreases by one at the clock edge. With both low, the count does not change.
- R3: A cycle with `prog_stb` high loads `prog_val` into the counter. This takes priority over a tick in the same cycle: there is no decrement and no terminal-count pulse.
- R4: A tick while the count is zero sets the count to 0xFFFF. It also drives `tc_pulse` high for exactly the one cycle that follows that clock edge.
- R5: A `latch_stb` accepted while no snapshot is held does three things: it copies the count as it stood before the edge, marks a snapshot as held, and points the next read at the low byte. The snapshot does not follow later ticks.
- R6: A `latch_stb` while a snapshot is held is ignored. The held value and the byte pointer are unchanged.
- R7: While a snapshot is held, the first read returns its low byte (bits 7:0). The next read returns its high byte (bits 15:8) and releases the snapshot, so later reads see the live count.
- R8: With no snapshot held, successive reads alternate between the low byte and the high byte of the live count, taken before the edge of each read. Reads never stop or alter the counting.
- R9: `rd_data` is registered. It takes the selected byte at the clock edge of a cycle with `rd_stb` high, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Count tick: decrement this cycle |
| prog_stb | input | 1 | Load `prog_val` into the counter |
| prog_val | input | 16 | New starting count |
| latch_stb | input | 1 | Request a snapshot of the count |
| rd_stb | input | 1 | Read one byte of the count |
| rd_data | output | 8 | Byte returned by the last read |
| tc_pulse | output | 1 | One-cycle pulse after wrapping from zero |

## Verification
The hardest state to reach is a held snapshot with the counter still running. In that state a second latch request arrives, and it must leave the frozen value alone. The stimulus reaches it by latching, then ticking several more cycles, then latching again before the two reads. Both bytes must then still match the first snapshot, and a later latch must capture the newer count. A second difficult case is a read that falls in the same cycle as a tick. The bench does this on two cycles in a row: the low byte must come from the count before the first tick, and the high byte from the count one tick later.

// File: rtl/ttc_pkg.sv
package ttc_pkg;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } byte_sel_e;

    typedef struct packed {
        logic      held;
        byte_sel_e sel;
    } rd_state_t;

    function automatic byte_sel_e next_sel(input byte_sel_e s);
        return (s == SEL_LO) ? SEL_HI : SEL_LO;
    endfunction

endpackage

// File: rtl/ttc_count_core.sv
module ttc_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             prog_stb,
    input  logic [CNT_W-1:0] prog_val,
    output logic [CNT_W-1:0] count_q,
    output logic             tc_q
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic at_zero;
    assign at_zero = (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            tc_q    <= 1'b0;
        end else begin
            tc_q <= 1'b0;
            if (prog_stb) begin
                count_q <= prog_val;
            end else if (tick_en) begin
                if (at_zero) begin
                    count_q <= ALL_ONES;
                    tc_q    <= 1'b1;
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ttc_readout.sv
module ttc_readout
    import ttc_pkg::*;
#(
    parameter int RD_W = 8,
    localparam int CNT_W = 2 * RD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch_stb,
    input  logic             rd_stb,
    input  logic [CNT_W-1:0] live_count,
    output logic [CNT_W-1:0] snap_q,
    output rd_state_t        st_q,
    output logic [RD_W-1:0]  rd_q
);
    function automatic logic [RD_W-1:0] half_of(input logic [CNT_W-1:0] v,
                                                input byte_sel_e s);
        return (s == SEL_HI) ? v[CNT_W-1:RD_W] : v[RD_W-1:0];
    endfunction

    logic [CNT_W-1:0] src;
    logic             take_latch;

    assign src        = st_q.held ? snap_q : live_count;
    assign take_latch = latch_stb && !st_q.held;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q  <= '0;
            st_q    <= '{held: 1'b0, sel: SEL_LO};
            rd_q    <= '0;
        end else begin
            if (rd_stb) begin
                rd_q <= half_of(src, st_q.sel);
            end
            if (take_latch) begin
                snap_q  <= live_count;
                st_q    <= '{held: 1'b1, sel: SEL_LO};
            end else if (rd_stb) begin
                st_q.sel <= next_sel(st_q.sel);
                if (st_q.held && st_q.sel == SEL_HI) begin
                    st_q.held <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/tick_timer_chan.sv
module tick_timer_chan
    import ttc_pkg::*;
#(
    parameter int RD_W = 8,
    localparam int CNT_W = 2 * RD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             prog_stb,
    input  logic [CNT_W-1:0] prog_val,
    input  logic             latch_stb,
    input  logic             rd_stb,
    output logic [RD_W-1:0]  rd_data,
    output logic             tc_pulse
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] snap_q;
    rd_state_t        rd_st;

    ttc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .prog_stb (prog_stb),
        .prog_val (prog_val),
        .count_q  (count_q),
        .tc_q     (tc_pulse)
    );

    ttc_readout #(.RD_W(RD_W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .latch_stb  (latch_stb),
        .rd_stb     (rd_stb),
        .live_count (count_q),
        .snap_q     (snap_q),
        .st_q       (rd_st),
        .rd_q       (rd_data)
    );
endmodule

// File: rtl/ttc_checker.sv
module ttc_checker
    import ttc_pkg::*;
#(
    parameter int RD_W = 8,
    localparam int CNT_W = 2 * RD_W
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             prog_stb,
    input logic [CNT_W-1:0] prog_val,
    input logic             latch_stb,
    input logic             rd_stb,
    input logic [RD_W-1:0]  rd_data,
    input logic             tc_pulse,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] snap_q,
    input rd_state_t        rd_st
);
    // R2
    a_r2_decrement: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !prog_stb && count_q != '0) |=> count_q == $past(count_q) - 1'b1);
    // R2
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !prog_stb) |=> $stable(count_q));
    // R3
    a_r3_prog_load: assert property (@(posedge clk) disable iff (rst)
        prog_stb |=> (count_q == $past(prog_val) && !tc_pulse));
    // R4
    a_r4_wrap_pulse: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !prog_stb && count_q == '0) |=> (count_q == {CNT_W{1'b1}} && tc_pulse));
    // R4
    a_r4_single_cycle: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !tc_pulse);
    // R5
    a_r5_latch_take: assert property (@(posedge clk) disable iff (rst)
        (latch_stb && !rd_st.held) |=> (rd_st.held && rd_st.sel == SEL_LO
                                       && snap_q == $past(count_q)));
    // R6
    a_r6_snap_frozen: assert property (@(posedge clk) disable iff (rst)
        rd_st.held |=> $stable(snap_q));
    // R7
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (rd_st.held && rd_stb && rd_st.sel == SEL_HI) |=> !rd_st.held);
    // R9
    a_r9_data_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));
endmodule

bind tick_timer_chan ttc_checker #(.RD_W(RD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .prog_stb  (prog_stb),
    .prog_val  (prog_val),
    .latch_stb (latch_stb),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .tc_pulse  (tc_pulse),
    .count_q   (count_q),
    .snap_q    (snap_q),
    .rd_st     (rd_st)
);

// File: tb/sim_tick_timer_chan.sv
`timescale 1ns/1ps
module sim_tick_timer_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        prog_stb = 1'b0;
    logic [15:0] prog_val = '0;
    logic        latch_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_data;
    logic        tc_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tick_timer_chan u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .prog_stb(prog_stb),
        .prog_val(prog_val), .latch_stb(latch_stb), .rd_stb(rd_stb),
        .rd_data(rd_data), .tc_pulse(tc_pulse)
    );

    // {start value, ticks before latch, expected snapshot}
    localparam logic [47:0] VEC [6] = '{
        {16'h1234, 16'd5,  16'h122F},
        {16'h0100, 16'd1,  16'h00FF},
        {16'hFFFF, 16'd16, 16'hFFEF},
        {16'h0003, 16'd3,  16'h0000},
        {16'h0002, 16'd4,  16'hFFFE},
        {16'h8000, 16'd0,  16'h8000}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic program_cnt(input logic [15:0] v);
        prog_stb = 1'b1; prog_val = v;
        step();
        prog_stb = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        for (int k = 0; k < n; k++) step();
        tick_en = 1'b0;
    endtask

    task automatic do_latch();
        latch_stb = 1'b1;
        step();
        latch_stb = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        rd_stb = 1'b1;
        step();
        rd_stb = 1'b0;
        b = rd_data;
    endtask

    task automatic read_word(input string tag, input logic [15:0] exp);
        logic [7:0] lo, hi;
        read_byte(lo);
        chk({tag, " low byte"}, {8'h00, lo}, {8'h00, exp[7:0]});
        read_byte(hi);
        chk({tag, " high byte"}, {8'h00, hi}, {8'h00, exp[15:8]});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] b;
        @(negedge clk);
        step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 rd_data after reset", {8'h00, rd_data}, 16'h0000);
        chk("R1 tc_pulse after reset", {15'd0, tc_pulse}, 16'h0000);
        read_word("R1 zero count", 16'h0000);

        // Table: R5 snapshot frozen while ticking continues, R2 decrement
        for (int i = 0; i < 6; i++) begin
            program_cnt(VEC[i][47:32]);
            ticks(int'(VEC[i][31:16]));
            do_latch();
            ticks(7);
            read_word($sformatf("R5 vector %0d", i), VEC[i][15:0]);
        end

        // R8 unlatched reads alternate
        program_cnt(16'hABCD);
        read_byte(b); chk("R8 first unlatched low", {8'h00, b}, 16'h00CD);
        read_byte(b); chk("R8 unlatched high", {8'h00, b}, 16'h00AB);
        read_byte(b); chk("R8 alternates back to low", {8'h00, b}, 16'h00CD);
        read_byte(b); chk("R8 second high", {8'h00, b}, 16'h00AB);

        // R8 reads alongside ticks; counting continues
        program_cnt(16'h0301);
        tick_en = 1'b1; rd_stb = 1'b1;
        step(); chk("R8 low while ticking", {8'h00, rd_data}, 16'h0001);
        step(); chk("R8 high one tick later", {8'h00, rd_data}, 16'h0003);
        tick_en = 1'b0; rd_stb = 1'b0;
        do_latch();
        read_word("R8 count after reading ticks", 16'h02FF);

        // R9 data holds without read strobe
        tick_en = 1'b1;
        step(); step(); step();
        tick_en = 1'b0;
        chk("R9 rd_data held", {8'h00, rd_data}, 16'h0002);

        // R6 latch while held is ignored, R7 release
        program_cnt(16'h0500);
        do_latch();
        ticks(3);
        do_latch();
        read_word("R6 first snapshot kept", 16'h0500);
        do_latch();
        read_word("R7 new snapshot after release", 16'h04FD);

        // R5 latch resets pointer to low byte
        program_cnt(16'h1234);
        read_byte(b); chk("R5 live low before latch", {8'h00, b}, 16'h0034);
        do_latch();
        read_word("R5 pointer reset by latch", 16'h1234);

        // R4 wrap and one-cycle terminal pulse
        program_cnt(16'h0002);
        ticks(2);
        chk("R4 no pulse before zero tick", {15'd0, tc_pulse}, 16'h0000);
        tick_en = 1'b1;
        step();
        tick_en = 1'b0;
        chk("R4 pulse after zero tick", {15'd0, tc_pulse}, 16'h0001);
        step();
        chk("R4 pulse lasts one cycle", {15'd0, tc_pulse}, 16'h0000);
        do_latch();
        read_word("R4 wrapped count", 16'hFFFF);

        // R3 program beats tick, even at zero
        program_cnt(16'h0000);
        tick_en = 1'b1; prog_stb = 1'b1; prog_val = 16'h0040;
        step();
        tick_en = 1'b0; prog_stb = 1'b0;
        chk("R3 no pulse when program wins", {15'd0, tc_pulse}, 16'h0000);
        do_latch();
        read_word("R3 program priority", 16'h0040);

        // R2 idle cycles do not change the count
        program_cnt(16'h0777);
        step(); step(); step();
        do_latch();
        read_word("R2 hold without tick", 16'h0777);

        finish_run();
    end
endmodule